// File: doc/BRIEF.md
# Receive-FIFO Flow-Delay RTS Control

This block decides the level of the request-to-send modem line from the fill level of a receive FIFO. It compares the fill level with a programmable flow-delay threshold. When the level reaches the threshold, an internal trigger is set. When automatic hardware flow control is on, that trigger drives RTS inactive, which tells the remote sender to pause.

The trigger is cleared only when the FIFO has drained to four entries below the threshold. Between those two levels the trigger keeps its value, so the line does not chatter while the level moves around near the threshold. A threshold below four turns the function off.

The trigger is exported only as a status flag. When hardware flow control is off, the RTS pin simply follows the software RTS request. The pin is active-low. The FIFO itself and any interrupt logic sit outside this block.

Top module: `flowdel_rts_ctrl`

## Requirements
- R1: While `rstN` is low and on the first cycle after it, `flowTrigSts` is 0. With `flowModeEn` = 1, `rtsN` is then 0.
- R2: When `flowThresh` >= 4 and `rxLevel` >= `flowThresh` at a rising edge, `flowTrigSts` is 1 after that edge.
- R3: When `flowThresh` >= 4 and `rxLevel` + 4 <= `flowThresh` at a rising edge, `flowTrigSts` is 0 after that edge.
- R4: When `flowThresh` >= 4 and `flowThresh` - 4 < `rxLevel` < `flowThresh` at a rising edge, `flowTrigSts` keeps its previous value.
- R5: When `flowThresh` < 4 at a rising edge, `flowTrigSts` is 0 after that edge, whatever the value of `rxLevel`.
- R6: With `flowModeEn` = 1, `rtsN` equals `flowTrigSts`: 1 (inactive) while the trigger holds off the sender, and 0 otherwise.
- R7: With `flowModeEn` = 0, `rtsN` is the inverse of `swRtsReq`. The trigger keeps being updated by R2 to R5.
- R8: With `flowModeEn` = 1, `swRtsReq` has no effect on `rtsN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxLevel | input | 6 | Current receive FIFO fill level |
| flowThresh | input | 6 | Flow-delay threshold; values below 4 turn the function off |
| flowModeEn | input | 1 | Automatic hardware flow-control mode |
| swRtsReq | input | 1 | Software RTS request (1 = request to send) |
| rtsN | output | 1 | RTS pin, active-low |
| flowTrigSts | output | 1 | Flow-delay trigger status flag |

## Verification
The hard case is the hysteresis band. Whether the trigger holds 1 or 0 there depends on whether the level last came from above the threshold or from below the release point, so a single input value cannot expose a fault in the hold logic. The stimulus therefore ramps the level fully up and then fully down for every threshold value, entering the band from both sides each time. A pseudo-random walk then adds threshold changes while the trigger is held, which is how the trigger gets cleared by the threshold dropping below four. Flow-control mode and the software request are toggled along the way, so R6 to R8 are checked in both trigger states.

// File: rtl/flowdel_pkg.sv
package flowdel_pkg;

  // Results of the level/threshold comparisons, driven by the datapath
  typedef struct packed {
    logic armed;      // threshold large enough to enable the function
    logic atTrig;     // level at or above threshold
    logic atRelease;  // level at or below the release point
  } cmpFlags_t;

  // Strobes from the control to the trigger register
  typedef struct packed {
    logic setTrig;
    logic clrTrig;
  } trigStrobe_t;

endpackage

// File: rtl/flowdel_datapath.sv
module flowdel_datapath
  import flowdel_pkg::*;
#(
  parameter int LVL_W      = 6,
  parameter int HYST       = 4,
  parameter int MIN_THRESH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] flowThresh,
  input  logic             flowModeEn,
  input  logic             swRtsReq,
  input  trigStrobe_t      strobe,
  output cmpFlags_t        flags,
  output logic             trigQ,
  output logic             rtsN
);

  localparam int EXT_W = LVL_W + 1;

  logic [EXT_W-1:0] levelExt;
  logic [EXT_W-1:0] threshExt;

  assign levelExt  = {1'b0, rxLevel};
  assign threshExt = {1'b0, flowThresh};

  // Wide compare so that adding the hysteresis cannot wrap
  always_comb begin
    flags.armed     = threshExt >= EXT_W'(MIN_THRESH);
    flags.atTrig    = levelExt >= threshExt;
    flags.atRelease = (levelExt + EXT_W'(HYST)) <= threshExt;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                trigQ <= 1'b0;
    else if (strobe.clrTrig)  trigQ <= 1'b0;
    else if (strobe.setTrig)  trigQ <= 1'b1;
  end

  // Pin is active-low; the trigger drives it high to hold off the sender
  assign rtsN = flowModeEn ? trigQ : ~swRtsReq;

endmodule

// File: rtl/flowdel_ctrl.sv
module flowdel_ctrl
  import flowdel_pkg::*;
(
  input  cmpFlags_t   flags,
  output trigStrobe_t strobe
);

  // Outside the band the trigger follows the level; inside it nothing fires
  always_comb begin
    strobe.clrTrig = !flags.armed || flags.atRelease;
    strobe.setTrig = flags.armed && flags.atTrig;
  end

endmodule

// File: rtl/flowdel_rts_ctrl.sv
module flowdel_rts_ctrl
  import flowdel_pkg::*;
#(
  parameter int LVL_W      = 6,
  parameter int HYST       = 4,
  parameter int MIN_THRESH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] flowThresh,
  input  logic             flowModeEn,
  input  logic             swRtsReq,
  output logic             rtsN,
  output logic             flowTrigSts
);

  cmpFlags_t   flags;
  trigStrobe_t strobe;

  flowdel_datapath #(
    .LVL_W(LVL_W), .HYST(HYST), .MIN_THRESH(MIN_THRESH)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .rxLevel    (rxLevel),
    .flowThresh (flowThresh),
    .flowModeEn (flowModeEn),
    .swRtsReq   (swRtsReq),
    .strobe     (strobe),
    .flags      (flags),
    .trigQ      (flowTrigSts),
    .rtsN       (rtsN)
  );

  flowdel_ctrl ctrl_i (
    .flags  (flags),
    .strobe (strobe)
  );

endmodule

// File: rtl/flowdel_rts_chk.sv
module flowdel_rts_chk #(
  parameter int LVL_W      = 6,
  parameter int HYST       = 4,
  parameter int MIN_THRESH = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [LVL_W-1:0] rxLevel,
  input logic [LVL_W-1:0] flowThresh,
  input logic             flowModeEn,
  input logic             swRtsReq,
  input logic             rtsN,
  input logic             flowTrigSts
);

  logic [LVL_W:0] lvlPlus;
  logic [LVL_W:0] thrExt;
  logic           armedC;

  assign lvlPlus = {1'b0, rxLevel} + (LVL_W+1)'(HYST);
  assign thrExt  = {1'b0, flowThresh};
  assign armedC  = thrExt >= (LVL_W+1)'(MIN_THRESH);

  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> !flowTrigSts);

  a_r2_set_at_thresh: assert property (@(posedge clk) disable iff (!rstN)
    (armedC && rxLevel >= flowThresh) |=> flowTrigSts);

  a_r3_release_low: assert property (@(posedge clk) disable iff (!rstN)
    (armedC && lvlPlus <= thrExt) |=> !flowTrigSts);

  a_r4_band_hold: assert property (@(posedge clk) disable iff (!rstN)
    (armedC && rxLevel < flowThresh && lvlPlus > thrExt) |=> $stable(flowTrigSts));

  a_r5_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !armedC |=> !flowTrigSts);

  a_r6_flow_pin: assert property (@(posedge clk) disable iff (!rstN)
    flowModeEn |-> (rtsN == flowTrigSts));

  a_r7_sw_pin: assert property (@(posedge clk) disable iff (!rstN)
    !flowModeEn |-> (rtsN == !swRtsReq));

endmodule

bind flowdel_rts_ctrl flowdel_rts_chk #(
  .LVL_W(LVL_W), .HYST(HYST), .MIN_THRESH(MIN_THRESH)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .rxLevel     (rxLevel),
  .flowThresh  (flowThresh),
  .flowModeEn  (flowModeEn),
  .swRtsReq    (swRtsReq),
  .rtsN        (rtsN),
  .flowTrigSts (flowTrigSts)
);

// File: tb/flowdel_rts_ctrl_tb_top.sv
module flowdel_rts_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic [5:0] rxLevel;
  logic [5:0] flowThresh;
  logic       flowModeEn;
  logic       swRtsReq;
  logic       rtsN;
  logic       flowTrigSts;

  int compared = 0;
  int mismatched = 0;
  bit expTrig = 1'b0;
  int unsigned lfsr = 32'h1234_5678;

  always #5 clk = ~clk;

  flowdel_rts_ctrl dut_i (
    .clk         (clk),
    .rstN        (rstN),
    .rxLevel     (rxLevel),
    .flowThresh  (flowThresh),
    .flowModeEn  (flowModeEn),
    .swRtsReq    (swRtsReq),
    .rtsN        (rtsN),
    .flowTrigSts (flowTrigSts)
  );

  task automatic check(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%b expected=%b (lvl=%0d thr=%0d fe=%b sw=%b) at %0t",
               req, act, exp, rxLevel, flowThresh, flowModeEn, swRtsReq, $time);
    end
  endtask

  // Called at a falling edge: apply inputs, advance one cycle, check
  task automatic step(input int lv, input int th, input bit fe, input bit sw);
    string tag;
    rxLevel = 6'(lv); flowThresh = 6'(th); flowModeEn = fe; swRtsReq = sw;
    if (th < 4)             begin expTrig = 1'b0; tag = "R5"; end
    else if (lv >= th)      begin expTrig = 1'b1; tag = "R2"; end
    else if (lv + 4 <= th)  begin expTrig = 1'b0; tag = "R3"; end
    else                    tag = "R4";
    @(negedge clk);
    check(tag, flowTrigSts, expTrig);
    if (fe) check(sw ? "R8" : "R6", rtsN, expTrig);
    else    check("R7", rtsN, !sw);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0; rxLevel = 6'd63; flowThresh = 6'd10;
    flowModeEn = 1'b1; swRtsReq = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", flowTrigSts, 1'b0);
    check("R1", rtsN, 1'b0);
    rxLevel = 6'd0;
    rstN = 1'b1;
    @(negedge clk);
    check("R1", flowTrigSts, 1'b0);
    check("R1", rtsN, 1'b0);
    expTrig = 1'b0;

    // Full ramp up then down for every threshold value
    for (int th = 0; th < 64; th++) begin
      for (int lv = 0; lv < 64; lv++)
        step(lv, th, (lv % 7) != 3, lv[1]);
      for (int lv = 63; lv >= 0; lv--)
        step(lv, th, (lv % 5) != 2, lv[0]);
    end

    // Pseudo-random walk including threshold changes while held
    begin
      int lv = 20;
      int th = 24;
      for (int i = 0; i < 4000; i++) begin
        lfsr = lfsr * 32'd1664525 + 32'd1013904223;
        lv = lv + int'(lfsr[18:16]) - 3;
        if (lv < 0) lv = 0;
        if (lv > 63) lv = 63;
        if (lfsr[27:24] == 4'd0) th = int'(lfsr[13:8]);
        step(lv, th, lfsr[29], lfsr[30]);
      end
    end

    finishRun();
  end

endmodule